// File: doc/BRIEF.md
# Inclusive Cache Slice Snoop Directory

This block is the tag and coherence directory for one slice of a banked, shared last-level cache that serves several cores. Each slice owns the addresses whose folded tag hash equals its own slice number. It keeps, for every line of a set-associative tag store, a MESI state and a presence vector with one bit per core. Because the cache holds everything the cores hold, the presence vector tells exactly which cores can have a copy, so snoops go only to those cores.

A request carries a core number, a physical address and a kind: read, ownership or non-cacheable. The slice looks up the set, snoops holders where coherence requires it, evicts a victim with back-invalidation snoops when a miss needs room, and sends line fills and non-cacheable accesses to the memory side. It finishes each transaction with a single response that gives the granted state. Only one transaction is in flight at a time. A later request, to the same line or any other, waits until the current one has answered. The line data, the interconnect transport and the memory controller lie outside the block.

Top module: `llc_snoop_dir`

## Requirements
- R1: The tag is addr[31:10], the set is addr[9:6] and the line offset is addr[5:0]. Hash bit j is the XOR of all tag bits whose index i satisfies i mod 2 == j. A request whose hash differs from SLICE_ID, or whose kind is 3 (reserved), is answered with rsp_err=1 in the cycle after acceptance. It issues no snoop and no memory request.
- R2: A read (kind 0) that misses and has an invalid way free issues no snoop. It issues one memory request with mem_nc=0 and the 64-byte aligned line address. After mem_done it answers with rsp_hit=0 and state E (state codes: I=0, S=1, E=2, M=3).
- R3: A read hit needs no snoop when no other core's presence bit is set, or when the line is in S. Its response comes two cycles after acceptance. The requester's bit is added, and the granted state is S if other bits remain set, otherwise E (M stays M).
- R4: A read hit on a line in E or M that another core holds sends a snoop with snp_inval=0 to exactly the other holders. After the acknowledgements it answers with state S.
- R5: An ownership request (kind 1) that hits sends a snoop with snp_inval=1 to every other core whose bit is set and never to the requester. It answers with state M and leaves only the requester's bit set.
- R6: A non-cacheable access (kind 2) issues one memory request with mem_nc=1 and answers with state I and rsp_hit=0. It does not change the directory.
- R7: Misses fill invalid ways first, so the first 16 distinct lines of a set cause no back-invalidation snoops.
- R8: When a set is full, the victim is chosen by a binary-tree pseudo-LRU over 16 ways. After filling ways in order and touching the first line again, the next miss evicts the ninth line filled. The slice sends snp_inval=1 with the victim's address to the victim's holders, and issues the memory request only after all acknowledgements.
- R9: A snoop completes only when every core in its mask has raised its snp_ack bit. The acknowledgements may come in different cycles, and the response or memory request follows the cycle after the last one.
- R10: req_ready is low from acceptance until the response cycle. A request held waiting is accepted after that and sees the directory as updated by the earlier one.
- R11: After reset all lines are invalid, req_ready is high, and snp_valid, mem_valid and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can accept a request |
| req_core | input | 2 | Requesting core |
| req_addr | input | 32 | Physical byte address |
| req_type | input | 2 | 0 read, 1 ownership, 2 non-cacheable, 3 reserved |
| snp_valid | output | 1 | Snoop issue pulse |
| snp_mask | output | 4 | Cores to snoop |
| snp_addr | output | 32 | Line address snooped |
| snp_inval | output | 1 | 1 invalidate, 0 downgrade to shared |
| snp_ack | input | 4 | Per-core snoop acknowledgement |
| mem_valid | output | 1 | Memory-side request pulse |
| mem_addr | output | 32 | Line address to memory side |
| mem_nc | output | 1 | 1 for non-cacheable access |
| mem_done | input | 1 | Memory side has completed the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_core | output | 2 | Core the response belongs to |
| rsp_state | output | 2 | Granted MESI state |
| rsp_hit | output | 1 | Request hit in the slice |
| rsp_err | output | 1 | Wrong slice or reserved kind |

## Verification
Two functions can meet in one cycle. A finishing transaction writes the tag store, and a waiting request is accepted and starts its tag read in the next cycle. The bench provokes this by holding a second request to the same line, an ownership request from another core, asserted while a read miss is served. It checks that req_ready stays low throughout. The second request must then hit and send an invalidating snoop to the first requester only. A second overlap, acknowledgements arriving in the same cycle as the snoop pulse versus one per cycle, is judged by the exact response cycle relative to the last acknowledgement.

// File: rtl/llc_dir_pkg.sv
package llc_dir_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_OWN = 2'd1, RQ_NC = 2'd2, RQ_RSVD = 2'd3} rq_t;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_LOOK = 2'd1, F_SNOOP = 2'd2, F_MEM = 2'd3} fsm_t;
endpackage

// File: rtl/slice_hash.sv
module slice_hash #(
  parameter int TAG_W = 22,
  parameter int SL_W  = 2
) (
  input  logic [TAG_W-1:0] tag,
  output logic [SL_W-1:0]  hash
);
  always_comb begin
    hash = '0;
    for (int i = 0; i < TAG_W; i++) hash[i % SL_W] = hash[i % SL_W] ^ tag[i];
  end
endmodule

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int WAYS = 16
) (
  input  logic [WAYS-2:0]         tree_in,
  input  logic [WAYS-1:0]         way_valid,
  input  logic [$clog2(WAYS)-1:0] touch,
  output logic [$clog2(WAYS)-1:0] victim,
  output logic [WAYS-2:0]         tree_out
);
  localparam int LW = $clog2(WAYS);

  always_comb begin
    int idx;
    logic [LW-1:0] pv;
    idx = 0;
    pv  = '0;
    for (int l = 0; l < LW; l++) begin
      pv[LW-1-l] = tree_in[idx];
      idx = 2 * idx + 1 + int'(tree_in[idx]);
    end
    victim = pv;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) victim = LW'(w);
  end

  always_comb begin
    int idx;
    tree_out = tree_in;
    idx = 0;
    for (int l = 0; l < LW; l++) begin
      tree_out[idx] = ~touch[LW-1-l];
      idx = 2 * idx + 1 + int'(touch[LW-1-l]);
    end
  end
endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NUM_CORES-1:0] mask,
  input  logic [NUM_CORES-1:0] ack,
  output logic [NUM_CORES-1:0] pend,
  output logic                 last
);
  assign last = (pend & ~ack) == '0;

  always_ff @(posedge clk) begin
    if (rst)       pend <= '0;
    else if (load) pend <= mask;
    else           pend <= pend & ~ack;
  end

  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> pend == '0);
endmodule

// File: rtl/llc_snoop_dir.sv
module llc_snoop_dir
  import llc_dir_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_SLICES = 4,
  parameter int SLICE_ID   = 0,
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [$clog2(NUM_CORES)-1:0]  req_core,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [1:0]                    req_type,
  output logic                          snp_valid,
  output logic [NUM_CORES-1:0]          snp_mask,
  output logic [ADDR_W-1:0]             snp_addr,
  output logic                          snp_inval,
  input  logic [NUM_CORES-1:0]          snp_ack,
  output logic                          mem_valid,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          mem_nc,
  input  logic                          mem_done,
  output logic                          rsp_valid,
  output logic [$clog2(NUM_CORES)-1:0]  rsp_core,
  output logic [1:0]                    rsp_state,
  output logic                          rsp_hit,
  output logic                          rsp_err
);
  localparam int CID_W = $clog2(NUM_CORES);
  localparam int SL_W  = $clog2(NUM_SLICES);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int ENT_W = TAG_W + NUM_CORES;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  fsm_t                 fsm;
  logic [CID_W-1:0]     q_core;
  rq_t                  q_type;
  logic [ADDR_W-1:0]    q_addr;
  logic                 q_hit;
  logic [WAY_W-1:0]     q_way;
  logic [NUM_CORES-1:0] q_pres;
  mesi_t                q_state;
  mesi_t                line_st [SETS][WAYS];
  logic [WAYS-2:0]      plru    [SETS];

  logic [SET_W-1:0] q_set;
  logic [TAG_W-1:0] q_tag;
  assign q_set = q_addr[OFF_W +: SET_W];
  assign q_tag = q_addr[ADDR_W-1 -: TAG_W];

  // Request decode
  logic [SL_W-1:0] req_hash;
  logic            req_bad;
  slice_hash #(.TAG_W(TAG_W), .SL_W(SL_W)) u_hash (
    .tag(req_addr[ADDR_W-1 -: TAG_W]), .hash(req_hash));
  assign req_bad   = (req_hash != SL_W'(SLICE_ID)) || (req_type == 2'd3);
  assign req_ready = (fsm == F_IDLE);

  // Tag and presence store: one synchronous-read RAM per way
  logic             rd_en, wr_en;
  logic [SET_W-1:0] rd_set;
  logic [WAY_W-1:0] wr_way;
  logic [ENT_W-1:0] wr_data;
  logic [TAG_W-1:0]     rd_tag  [WAYS];
  logic [NUM_CORES-1:0] rd_pres [WAYS];
  assign rd_en  = (fsm == F_IDLE) && req_valid;
  assign rd_set = req_addr[OFF_W +: SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] mem [SETS];
    logic [ENT_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w)) mem[q_set] <= wr_data;
      if (rd_en) rd_q <= mem[rd_set];
    end
    assign rd_tag[w]  = rd_q[ENT_W-1 -: TAG_W];
    assign rd_pres[w] = rd_q[NUM_CORES-1:0];
  end

  // Lookup
  logic [WAYS-1:0]      way_valid;
  logic                 hit_any;
  logic [WAY_W-1:0]     hit_way, victim;
  logic [NUM_CORES-1:0] req_oh, hit_pres, snp_need, snp_pick, cur_pres, new_pres;
  mesi_t                hit_state, cur_state, new_state;
  logic [WAYS-2:0]      tree_upd;
  logic [ADDR_W-1:0]    vic_addr;

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      way_valid[w] = line_st[q_set][w] != ST_I;
      if (way_valid[w] && rd_tag[w] == q_tag) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  plru_tree #(.WAYS(WAYS)) u_tree (
    .tree_in(plru[q_set]), .way_valid(way_valid), .touch(wr_way),
    .victim(victim), .tree_out(tree_upd));

  assign req_oh    = NUM_CORES'(1) << q_core;
  assign hit_pres  = rd_pres[hit_way];
  assign hit_state = line_st[q_set][hit_way];
  assign snp_need  = (q_type == RQ_OWN || hit_state == ST_E || hit_state == ST_M)
                     ? (hit_pres & ~req_oh) : '0;
  assign snp_pick  = hit_any ? snp_need : (way_valid[victim] ? rd_pres[victim] : '0);
  assign vic_addr  = {rd_tag[victim], q_set, OFF_W'(0)};

  assign cur_pres  = (fsm == F_LOOK) ? hit_pres  : q_pres;
  assign cur_state = (fsm == F_LOOK) ? hit_state : q_state;
  assign new_pres  = (fsm == F_MEM || q_type == RQ_OWN) ? req_oh : (cur_pres | req_oh);
  always_comb begin
    if (q_type == RQ_OWN)                new_state = ST_M;
    else if (fsm == F_MEM)               new_state = ST_E;
    else if ((cur_pres & ~req_oh) != '0) new_state = ST_S;
    else if (cur_state == ST_M)          new_state = ST_M;
    else                                 new_state = ST_E;
  end

  // Snoop acknowledgement collection
  logic [NUM_CORES-1:0] trk_pend;
  logic                 trk_last;
  snoop_tracker #(.NUM_CORES(NUM_CORES)) u_trk (
    .clk(clk), .rst(rst), .load(fsm == F_LOOK && snp_pick != '0),
    .mask(snp_pick), .ack(snp_ack), .pend(trk_pend), .last(trk_last));

  // Directory commit
  logic commit_hit, commit_fill;
  assign commit_hit  = (fsm == F_LOOK && hit_any && snp_need == '0) ||
                       (fsm == F_SNOOP && q_hit && trk_last);
  assign commit_fill = (fsm == F_MEM && mem_done && q_type != RQ_NC);
  assign wr_en   = commit_hit || commit_fill;
  assign wr_way  = (fsm == F_LOOK) ? hit_way : q_way;
  assign wr_data = {q_tag, new_pres};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        plru[s] <= '0;
        for (int w = 0; w < WAYS; w++) line_st[s][w] <= ST_I;
      end
    end else begin
      if (wr_en) begin
        line_st[q_set][wr_way] <= new_state;
        plru[q_set]            <= tree_upd;
      end else if (fsm == F_SNOOP && !q_hit && trk_last) begin
        line_st[q_set][q_way] <= ST_I;
      end
    end
  end

  // Transaction sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm <= F_IDLE; q_core <= '0; q_type <= RQ_READ; q_addr <= '0;
      q_hit <= 1'b0; q_way <= '0; q_pres <= '0; q_state <= ST_I;
      snp_valid <= 1'b0; snp_mask <= '0; snp_addr <= '0; snp_inval <= 1'b0;
      mem_valid <= 1'b0; mem_addr <= '0; mem_nc <= 1'b0;
      rsp_valid <= 1'b0; rsp_core <= '0; rsp_state <= 2'd0; rsp_hit <= 1'b0; rsp_err <= 1'b0;
    end else begin
      snp_valid <= 1'b0;
      mem_valid <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (fsm)
        F_IDLE: if (req_valid) begin
          q_core <= req_core;
          q_type <= rq_t'(req_type);
          q_addr <= req_addr & LINE_MASK;
          if (req_bad) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_hit <= 1'b0;
            rsp_state <= ST_I; rsp_core <= req_core;
          end else if (req_type == RQ_NC) begin
            mem_valid <= 1'b1; mem_nc <= 1'b1; mem_addr <= req_addr & LINE_MASK;
            fsm <= F_MEM;
          end else begin
            fsm <= F_LOOK;
          end
        end
        F_LOOK: begin
          q_hit   <= hit_any;
          q_way   <= hit_any ? hit_way : victim;
          q_pres  <= hit_pres;
          q_state <= hit_state;
          if (snp_pick != '0) begin
            snp_valid <= 1'b1; snp_mask <= snp_pick;
            snp_addr  <= hit_any ? q_addr : vic_addr;
            snp_inval <= !hit_any || q_type == RQ_OWN;
            fsm <= F_SNOOP;
          end else if (hit_any) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_hit <= 1'b1;
            rsp_state <= new_state; rsp_core <= q_core;
            fsm <= F_IDLE;
          end else begin
            mem_valid <= 1'b1; mem_nc <= 1'b0; mem_addr <= q_addr;
            fsm <= F_MEM;
          end
        end
        F_SNOOP: if (trk_last) begin
          if (q_hit) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_hit <= 1'b1;
            rsp_state <= new_state; rsp_core <= q_core;
            fsm <= F_IDLE;
          end else begin
            mem_valid <= 1'b1; mem_nc <= 1'b0; mem_addr <= q_addr;
            fsm <= F_MEM;
          end
        end
        F_MEM: if (mem_done) begin
          rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_hit <= 1'b0;
          rsp_state <= (q_type == RQ_NC) ? ST_I : new_state; rsp_core <= q_core;
          fsm <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  // R1
  err_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> $past(req_valid && req_ready));
  // R3
  snp_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> snp_mask != '0);
  // R5
  snp_not_self_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_addr == q_addr) |-> !snp_mask[q_core]);
  // R8
  mem_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> trk_pend == '0);
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_bad) |=> !req_ready);
  // R2
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && q_type != RQ_NC) |-> rsp_state != 2'd0);
endmodule

// File: tb/llc_snoop_dir_test.sv
module llc_snoop_dir_test;
  localparam int NC = 4, AW = 32, TW = 22;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_ready;
  logic [1:0]    req_core = 0, req_type = 0;
  logic [AW-1:0] req_addr = 0;
  logic          snp_valid, snp_inval;
  logic [NC-1:0] snp_mask, snp_ack = 0;
  logic [AW-1:0] snp_addr, mem_addr;
  logic          mem_valid, mem_nc, mem_done = 0;
  logic          rsp_valid, rsp_hit, rsp_err;
  logic [1:0]    rsp_core, rsp_state;

  llc_snoop_dir uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_addr(req_addr), .req_type(req_type),
    .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_addr(snp_addr),
    .snp_inval(snp_inval), .snp_ack(snp_ack), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_nc(mem_nc), .mem_done(mem_done),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_state(rsp_state),
    .rsp_hit(rsp_hit), .rsp_err(rsp_err));

  int n_chk = 0, n_fail = 0, cyc_total = 0;
  int ack_mode = 0;
  int g_rsp_cyc, g_snp_n, g_mem_n, g_mem_cyc, g_ack_cyc, g_ready_leak;
  logic [1:0] g_state, g_core; logic g_hit, g_err, g_inval, g_nc;
  logic [NC-1:0] g_mask; logic [AW-1:0] g_saddr, g_maddr;

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int seed, input int set);
    logic [TW-1:0] t; logic [1:0] h;
    t = TW'(seed) << 2;
    h = 0;
    for (int i = 0; i < TW; i++) h[i % 2] ^= t[i];
    t[1:0] = t[1:0] ^ h;
    return {t, 4'(set), 6'd0};
  endfunction

  task automatic issue(input int core, input logic [AW-1:0] a, input int kind);
    @(negedge clk);
    req_valid = 1; req_core = 2'(core); req_addr = a; req_type = 2'(kind);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // Serves snoops and memory requests until the response; cycles counted from acceptance.
  task automatic serve();
    logic [NC-1:0] pend; int mcnt; int c;
    pend = 0; mcnt = 0; c = 1;
    g_snp_n = 0; g_mem_n = 0; g_mem_cyc = -1; g_ack_cyc = -1; g_ready_leak = 0;
    forever begin
      snp_ack = 0; mem_done = 0;
      if (rsp_valid) begin
        g_rsp_cyc = c; g_state = rsp_state; g_hit = rsp_hit; g_err = rsp_err; g_core = rsp_core;
        break;
      end
      if (req_ready) g_ready_leak++;
      if (snp_valid) begin
        g_snp_n++; g_mask = snp_mask; g_saddr = snp_addr; g_inval = snp_inval; pend = snp_mask;
      end
      if (pend != 0) begin
        snp_ack = (ack_mode == 0) ? pend : (pend & (~pend + 1'b1));
        pend = pend & ~snp_ack;
        if (pend == 0) g_ack_cyc = c;
      end
      if (mem_valid) begin
        g_mem_n++; g_maddr = mem_addr; g_nc = mem_nc; g_mem_cyc = c; mcnt = 2;
      end
      if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) mem_done = 1;
      end
      if (c > 300) begin
        check("R9", "response timeout", 0, 1);
        break;
      end
      @(negedge clk);
      c++;
    end
    snp_ack = 0; mem_done = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11", "req_ready after reset", req_ready, 1);
    check("R11", "snp_valid after reset", snp_valid, 0);
    check("R11", "mem_valid after reset", mem_valid, 0);
    check("R11", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_errors();
    logic [AW-1:0] bad;
    bad = mk(3, 0) ^ 32'h0000_0400;
    issue(0, bad, 0); serve();
    check("R1", "wrong slice err", g_err, 1);
    check("R1", "err latency", g_rsp_cyc, 1);
    check("R1", "err no snoop/mem", g_snp_n + g_mem_n, 0);
    issue(1, mk(3, 0), 3); serve();
    check("R1", "reserved kind err", g_err, 1);
    check("R1", "reserved no memory", g_mem_n, 0);
  endtask

  // Line A in set 1: R2, R3, R4, R5, R6, R9
  task automatic t_line_a();
    logic [AW-1:0] a;
    a = mk(5, 1);
    ack_mode = 0;
    issue(1, a | 32'h24, 0); serve();
    check("R2", "miss memory count", g_mem_n, 1);
    check("R2", "miss line address", g_maddr, a);
    check("R2", "miss mem_nc", g_nc, 0);
    check("R2", "miss no snoop", g_snp_n, 0);
    check("R2", "miss state E", g_state, 2);
    check("R2", "miss rsp_hit", g_hit, 0);
    check("R2", "rsp_core", g_core, 1);
    issue(2, a, 0); serve();
    check("R4", "downgrade snoop mask", g_mask, 4'b0010);
    check("R4", "downgrade inval", g_inval, 0);
    check("R4", "shared grant", g_state, 1);
    check("R9", "rsp after ack", g_rsp_cyc, g_ack_cyc + 1);
    issue(3, a, 0); serve();
    check("R3", "shared read no snoop", g_snp_n, 0);
    check("R3", "shared read latency", g_rsp_cyc, 2);
    check("R3", "shared read state", g_state, 1);
    ack_mode = 1;
    issue(0, a, 1); serve();
    check("R5", "inval snoop mask", g_mask, 4'b1110);
    check("R5", "inval flag", g_inval, 1);
    check("R5", "ownership grant M", g_state, 3);
    check("R9", "staggered ack wait", g_rsp_cyc, g_ack_cyc + 1);
    check("R9", "staggered ack cycles", g_ack_cyc, 4);
    ack_mode = 0;
    issue(1, a, 0); serve();
    check("R5", "only owner remains", g_mask, 4'b0001);
    check("R4", "owner downgrade state", g_state, 1);
    issue(2, a, 2); serve();
    check("R6", "nc memory", g_mem_n, 1);
    check("R6", "nc flag", g_nc, 1);
    check("R6", "nc state I", g_state, 0);
    check("R6", "nc no snoop", g_snp_n, 0);
    issue(3, a, 0); serve();
    check("R6", "line kept after nc", g_hit, 1);
    check("R3", "sharer read no snoop", g_snp_n, 0);
  endtask

  // Set 5: fill, touch, evict by tree pseudo-LRU (R7, R8)
  task automatic t_evict();
    int leak;
    leak = 0;
    ack_mode = 0;
    for (int i = 0; i < 16; i++) begin
      issue(i % 4, mk(100 + i, 5), 0); serve();
      leak += g_snp_n;
      if (g_mem_n != 1) leak += 100;
    end
    check("R7", "fills without back-invalidation", leak, 0);
    issue(0, mk(100, 5), 0); serve();
    check("R8", "touch first line hit", g_hit, 1);
    check("R3", "sole holder read no snoop", g_snp_n, 0);
    check("R3", "sole holder state E", g_state, 2);
    issue(1, mk(116, 5), 0); serve();
    check("R8", "back-inval address", g_saddr, mk(108, 5));
    check("R8", "back-inval mask", g_mask, 4'b0001);
    check("R8", "back-inval flag", g_inval, 1);
    check("R8", "memory after acks", g_mem_cyc > g_ack_cyc, 1);
    check("R8", "new line grant E", g_state, 2);
    issue(2, mk(108, 5), 0); serve();
    check("R8", "evicted line misses", g_hit, 0);
    issue(3, mk(100, 5), 0); serve();
    check("R8", "touched line kept", g_hit, 1);
  endtask

  // Held second request to the same line (R10)
  task automatic t_conc();
    logic [AW-1:0] x;
    x = mk(40, 9);
    issue(0, x, 0);
    req_valid = 1; req_core = 2; req_addr = x; req_type = 1;
    serve();
    check("R10", "ready low while busy", g_ready_leak, 0);
    check("R10", "first grant E", g_state, 2);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    serve();
    check("R10", "second sees update hit", g_hit, 1);
    check("R10", "second snoops first only", g_mask, 4'b0001);
    check("R5", "second grant M", g_state, 3);
    check("R10", "second rsp core", g_core, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_errors();
    t_line_a();
    t_evict();
    t_conc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule